// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers three interrupt sources for a small processor core: a one-cycle overflow pulse from a timer, a change of level on any pin of an input port, and a falling edge on a dedicated external interrupt pin. Each event sets a sticky pending bit in a flag register. A mask register selects which pending bits may raise a request. A global enable bit then gates the request towards the core.

Software reads the flag register through a mask: the value returned is the flags ANDed with the mask. A write to the flag register can only clear bits, so an event is never created by software. The global enable is set by enable and return-from-interrupt strobes. It is cleared by a disable strobe or when the core accepts an interrupt. A wake-up output reports any pending, unmasked flag whatever the global enable is, so a sleep controller can use it.

The port pins and the external pin are asynchronous. They pass through synchronisers before edge and change detection. The external pin is only watched while its function-select input is high.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag read value, the mask read value, the global enable, the request and the wake-up output are all zero.
- R2: A high level on the timer overflow input at a clock edge sets flag bit 0, which is visible in the next cycle.
- R3: A change of any single bit of the port input, in either direction, sets flag bit 1 at the third rising clock edge after the change; port levels present when reset is released set no flag.
- R4: With the select input high, a falling edge on the external pin sets flag bit 2; a rising edge sets nothing.
- R5: With the select input low, a falling edge on the external pin leaves flag bit 2 clear.
- R6: Flags stay set until cleared; a flag-register write clears each flag bit 0 to 2 whose write-data bit is 0 and never sets a bit; flag read bits 3 to 7 are always 0.
- R7: When an event and a clearing write to the same flag bit arrive at the same edge, the flag ends up set.
- R8: The flag read value equals flags AND mask; a mask write stores write-data bits 0 to 2 (bit 0 timer, bit 1 port, bit 2 external), and mask read bits 3 to 7 are 0.
- R9: The global enable is set by the enable strobe and cleared by the disable strobe or the accept strobe; when set and clear strobes coincide, the enable ends up clear.
- R10: The request output is high exactly when the global enable is set and at least one flag bit is set together with its mask bit.
- R11: The wake-up output is high exactly when at least one flag bit is set together with its mask bit, whatever the global enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse, synchronous |
| port_pins_i | input | PORT_W | Asynchronous port pin levels |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| ext_sel_i | input | 1 | External interrupt function select |
| flag_wr_i | input | 1 | Write strobe for the flag register (clear only) |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | 8 | Write data for both registers |
| flag_rdata_o | output | 8 | Flags ANDed with mask |
| mask_rdata_o | output | 8 | Mask register read value |
| gie_set_i | input | 1 | Enable or return-from-interrupt strobe |
| gie_clr_i | input | 1 | Disable strobe |
| irq_ack_i | input | 1 | Core accepted an interrupt |
| gie_o | output | 1 | Global enable state |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up indication |

## Verification
The assertions check on every cycle the rules that hold locally. A timer pulse leaves flag 0 set, and that flag rises only after a pulse. Flags hold without a write, and an event wins over a same-edge clear. Flag 2 rises only when selected. Read bits stay inside the mask, the request implies enable and wake-up, and the enable strobes are obeyed. The bench scenarios show what needs whole sequences: the three-edge latency of the port path, silence at reset release, rising edges and deselected edges that do nothing, and sweeps over all flag, mask and enable combinations and all clearing write values.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants for the interrupt flag and mask controller.
// Assumes an 8-bit register interface and three interrupt sources.
package irq_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned NUM_SRC = 3;
    // Bit positions are behaviour: software decodes them.
    localparam int unsigned SRC_TMR  = 0;
    localparam int unsigned SRC_PORT = 1;
    localparam int unsigned SRC_EXT  = 2;

    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [NUM_SRC-1:0] src_t;
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency is promised).
module irq_sync #(
    parameter int unsigned W       = 8,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {W{RST_VAL}};
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                // Pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= {W{RST_VAL}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_event_detect.sv
// Module irq_event_detect
// Synchronises the port and external pins, then produces one-cycle
// pulses for "any port bit changed" and "external pin fell".
// Detection is held off after reset until the previous-sample
// registers hold real pin data, so reset-release levels raise nothing.
// The external path is gated by the function-select input.
module irq_event_detect #(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_pins_i,
    input  logic              ext_pin_i,
    input  logic              ext_sel_i,
    output logic              port_chg_o,
    output logic              ext_fall_o
);
    localparam int unsigned FILL  = SYNC_STAGES + 1;
    localparam int unsigned CNT_W = $clog2(FILL + 1);
    localparam logic [CNT_W-1:0] FILL_V = CNT_W'(FILL);

    logic [PORT_W-1:0] port_sync;
    logic [PORT_W-1:0] port_prev_q;
    logic [0:0]        ext_sync;
    logic              ext_prev_q;
    logic [CNT_W-1:0]  arm_cnt_q;
    logic              armed;

    irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_port_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (port_pins_i),
        .q_o   (port_sync)
    );

    irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_pin_i),
        .q_o   (ext_sync)
    );

    // Count edges since reset until the compare path holds valid data.
    always_ff @(posedge clk) begin
        if (!rst_n)              arm_cnt_q <= '0;
        else if (arm_cnt_q != FILL_V) arm_cnt_q <= arm_cnt_q + 1'b1;
    end

    assign armed = (arm_cnt_q == FILL_V);

    // Keep the previous synchronised sample of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_prev_q <= '0;
            ext_prev_q  <= 1'b1;
        end else begin
            port_prev_q <= port_sync;
            ext_prev_q  <= ext_sync[0];
        end
    end

    // Flag any difference on the port and a high-to-low on the pin.
    always_comb begin
        port_chg_o = armed && (port_sync != port_prev_q);
        ext_fall_o = armed && ext_sel_i && ext_prev_q && !ext_sync[0];
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank
// Holds the sticky pending flags and the mask register.
// Events set flags; software writes can only clear them, and an event
// wins over a clear in the same cycle. Reads return flags AND mask.
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_t event_i,
    input  logic flag_wr_i,
    input  logic mask_wr_i,
    input  src_t wdata_i,
    output src_t flags_o,
    output src_t mask_o,
    output src_t pend_o
);
    src_t flag_q;
    src_t mask_q;
    src_t keep;

    // Bits kept by a write: a zero in the write data clears.
    always_comb begin
        keep = flag_wr_i ? wdata_i : '1;
    end

    // Update flags: clear by write, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & keep) | event_i;
    end

    // Load the mask on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    assign flags_o = flag_q;
    assign mask_o  = mask_q;
    assign pend_o  = flag_q & mask_q;
endmodule

// File: rtl/irq_enable_out.sv
// Module irq_enable_out
// Global interrupt enable and the request / wake-up outputs.
// Clear strobes (disable, accept) take priority over the set strobe.
module irq_enable_out
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie_set_i,
    input  logic gie_clr_i,
    input  logic irq_ack_i,
    input  src_t pend_i,
    output logic gie_o,
    output logic irq_o,
    output logic wake_o
);
    logic gie_q;

    // Track the global enable with clear-over-set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gie_q <= 1'b0;
        else if (gie_clr_i || irq_ack_i) gie_q <= 1'b0;
        else if (gie_set_i)              gie_q <= 1'b1;
    end

    // Drive request and wake-up from the pending vector.
    always_comb begin
        wake_o = |pend_i;
        irq_o  = gie_q && (|pend_i);
    end

    assign gie_o = gie_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module irq_flag_ctrl
// Top of the interrupt flag and mask controller: event detection,
// flag/mask registers and the enable/request stage.
// Assumes tmr_ovf_i is synchronous to clk; pins may be asynchronous.
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_ovf_i,
    input  logic [PORT_W-1:0] port_pins_i,
    input  logic              ext_pin_i,
    input  logic              ext_sel_i,
    input  logic              flag_wr_i,
    input  logic              mask_wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        flag_rdata_o,
    output logic [7:0]        mask_rdata_o,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              irq_ack_i,
    output logic              gie_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic port_chg;
    logic ext_fall;
    src_t events;
    src_t flags_raw;
    src_t mask_raw;
    src_t pend;
    logic unused_wdata_hi;

    irq_event_detect #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_pins_i (port_pins_i),
        .ext_pin_i   (ext_pin_i),
        .ext_sel_i   (ext_sel_i),
        .port_chg_o  (port_chg),
        .ext_fall_o  (ext_fall)
    );

    // Place each source on its flag bit.
    always_comb begin
        events           = '0;
        events[SRC_TMR]  = tmr_ovf_i;
        events[SRC_PORT] = port_chg;
        events[SRC_EXT]  = ext_fall;
    end

    irq_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (events),
        .flag_wr_i (flag_wr_i),
        .mask_wr_i (mask_wr_i),
        .wdata_i   (wdata_i[NUM_SRC-1:0]),
        .flags_o   (flags_raw),
        .mask_o    (mask_raw),
        .pend_o    (pend)
    );

    irq_enable_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .gie_set_i (gie_set_i),
        .gie_clr_i (gie_clr_i),
        .irq_ack_i (irq_ack_i),
        .pend_i    (pend),
        .gie_o     (gie_o),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    assign flag_rdata_o    = {{PAD_W{1'b0}}, pend};
    assign mask_rdata_o    = {{PAD_W{1'b0}}, mask_raw};
    assign unused_wdata_hi = ^wdata_i[REG_W-1:NUM_SRC];
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module irq_flag_ctrl_chk
// Cycle-level checks for irq_flag_ctrl, attached by bind below.
module irq_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf_i,
    input logic       ext_sel_i,
    input logic       flag_wr_i,
    input logic       gie_set_i,
    input logic       gie_clr_i,
    input logic       irq_ack_i,
    input logic [2:0] flags_raw,
    input logic [7:0] flag_rdata_o,
    input logic [7:0] mask_rdata_o,
    input logic       gie_o,
    input logic       irq_o,
    input logic       wake_o
);
    a_r2_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_i |=> flags_raw[0]);

    a_r6_tmr_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_raw[0]) |-> $past(tmr_ovf_i));

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr_i && flags_raw != 3'b000) |=> ((flags_raw & $past(flags_raw)) == $past(flags_raw)));

    a_r6_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rdata_o[7:3] == 5'b0);

    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && tmr_ovf_i) |=> flags_raw[0]);

    a_r5_ext_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_raw[2]) |-> $past(ext_sel_i));

    a_r8_read_inside_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata_o & ~mask_rdata_o) == 8'b0);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr_i || irq_ack_i) |=> !gie_o);

    a_r9_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_set_i && !gie_clr_i && !irq_ack_i) |=> gie_o);

    a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_o && wake_o));

    a_r11_wake_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == (flag_rdata_o != 8'b0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_ovf_i    (tmr_ovf_i),
    .ext_sel_i    (ext_sel_i),
    .flag_wr_i    (flag_wr_i),
    .gie_set_i    (gie_set_i),
    .gie_clr_i    (gie_clr_i),
    .irq_ack_i    (irq_ack_i),
    .flags_raw    (flags_raw),
    .flag_rdata_o (flag_rdata_o),
    .mask_rdata_o (mask_rdata_o),
    .gie_o        (gie_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
);

// File: tb/irq_flag_ctrl_tb.sv
// Bench for irq_flag_ctrl: directed timing checks plus sweeps over
// all flag, mask and enable combinations. Drives and samples on the
// falling edge.
module irq_flag_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_ovf_i = 1'b0;
    logic [7:0] port_pins_i = 8'hA5;
    logic       ext_pin_i = 1'b1;
    logic       ext_sel_i = 1'b1;
    logic       flag_wr_i = 1'b0;
    logic       mask_wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] flag_rdata_o;
    logic [7:0] mask_rdata_o;
    logic       gie_set_i = 1'b0;
    logic       gie_clr_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       gie_o;
    logic       irq_o;
    logic       wake_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_ovf_i    (tmr_ovf_i),
        .port_pins_i  (port_pins_i),
        .ext_pin_i    (ext_pin_i),
        .ext_sel_i    (ext_sel_i),
        .flag_wr_i    (flag_wr_i),
        .mask_wr_i    (mask_wr_i),
        .wdata_i      (wdata_i),
        .flag_rdata_o (flag_rdata_o),
        .mask_rdata_o (mask_rdata_o),
        .gie_set_i    (gie_set_i),
        .gie_clr_i    (gie_clr_i),
        .irq_ack_i    (irq_ack_i),
        .gie_o        (gie_o),
        .irq_o        (irq_o),
        .wake_o       (wake_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_flags(input logic [7:0] v);
        flag_wr_i = 1'b1; wdata_i = v;
        cyc(1);
        flag_wr_i = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_wr_i = 1'b1; wdata_i = v;
        cyc(1);
        mask_wr_i = 1'b0;
    endtask

    task automatic gie_pulse(input logic s, input logic c, input logic a);
        gie_set_i = s; gie_clr_i = c; irq_ack_i = a;
        cyc(1);
        gie_set_i = 1'b0; gie_clr_i = 1'b0; irq_ack_i = 1'b0;
    endtask

    // Raise the flags named in p (bit 0 timer, 1 port, 2 external).
    task automatic set_flags(input logic [2:0] p);
        tmr_ovf_i = p[0];
        if (p[1]) port_pins_i[0] = ~port_pins_i[0];
        if (p[2]) ext_pin_i = 1'b0;
        cyc(1);
        tmr_ovf_i = 1'b0;
        cyc(4);
        ext_pin_i = 1'b1;
        cyc(4);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        cyc(5);
        rst_n = 1'b1;
        cyc(6);
        // R1: reset state at the outputs
        check("R1 flags", flag_rdata_o, 8'h00);
        check("R1 mask", mask_rdata_o, 8'h00);
        check("R1 gie", {7'b0, gie_o}, 8'h00);
        check("R1 irq", {7'b0, irq_o}, 8'h00);
        check("R1 wake", {7'b0, wake_o}, 8'h00);
        // R3: pins held nonzero through reset release set nothing
        wr_mask(8'hFF);
        check("R8 mask upper zero", mask_rdata_o, 8'h07);
        check("R3 no flag at reset release", flag_rdata_o, 8'h00);

        // R2: timer pulse visible one cycle later
        tmr_ovf_i = 1'b1;
        cyc(1);
        tmr_ovf_i = 1'b0;
        check("R2 timer flag", flag_rdata_o, 8'h01);
        wr_flags(8'h00);
        check("R6 clear", flag_rdata_o, 8'h00);

        // R3: each port bit, three-edge latency
        for (int i = 0; i < 8; i++) begin
            port_pins_i[i] = ~port_pins_i[i];
            cyc(2);
            check("R3 not before third edge", flag_rdata_o, 8'h00);
            cyc(1);
            check("R3 port change flag", flag_rdata_o, 8'h02);
            cyc(2);
            wr_flags(8'h00);
        end

        // R4: falling edge sets, rising edge does not
        ext_sel_i = 1'b1;
        ext_pin_i = 1'b0;
        cyc(4);
        check("R4 falling edge", flag_rdata_o, 8'h04);
        wr_flags(8'h00);
        ext_pin_i = 1'b1;
        cyc(5);
        check("R4 rising edge ignored", flag_rdata_o, 8'h00);

        // R5: deselected pin ignored
        ext_sel_i = 1'b0;
        ext_pin_i = 1'b0;
        cyc(5);
        check("R5 deselected fall", flag_rdata_o, 8'h00);
        ext_pin_i = 1'b1;
        cyc(4);
        ext_sel_i = 1'b1;
        cyc(2);

        // R6: every clearing write value, then no set by write
        for (int w = 0; w < 8; w++) begin
            set_flags(3'b111);
            check("R6 all flags sticky", flag_rdata_o, 8'h07);
            wr_flags(8'hF8 | 8'(w));
            check("R6 clear by zero bits", flag_rdata_o, 8'(w));
            wr_flags(8'hFF);
            check("R6 write cannot set", flag_rdata_o, 8'(w));
            wr_flags(8'h00);
        end

        // R7: event and clearing write at the same edge
        set_flags(3'b010);
        tmr_ovf_i = 1'b1; flag_wr_i = 1'b1; wdata_i = 8'h00;
        cyc(1);
        tmr_ovf_i = 1'b0; flag_wr_i = 1'b0;
        check("R7 event beats clear", flag_rdata_o, 8'h01);
        wr_flags(8'h00);

        // R8, R10, R11: all flag, mask and enable combinations
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [2:0] pm;
                    wr_mask(8'h07);
                    wr_flags(8'h00);
                    set_flags(3'(p));
                    wr_mask(8'(m) | 8'hF0);
                    if (g == 1) gie_pulse(1'b1, 1'b0, 1'b0);
                    else        gie_pulse(1'b0, 1'b1, 1'b0);
                    pm = 3'(p) & 3'(m);
                    check("R8 masked read", flag_rdata_o, {5'b0, pm});
                    check("R8 mask readback", mask_rdata_o, 8'(m));
                    check("R10 request", {7'b0, irq_o}, {7'b0, (g == 1) && (pm != 3'b0)});
                    check("R11 wake", {7'b0, wake_o}, {7'b0, pm != 3'b0});
                end
            end
        end

        // R9: strobe priorities
        gie_pulse(1'b1, 1'b0, 1'b0);
        check("R9 set", {7'b0, gie_o}, 8'h01);
        gie_pulse(1'b1, 1'b1, 1'b0);
        check("R9 disable wins", {7'b0, gie_o}, 8'h00);
        gie_pulse(1'b1, 1'b0, 1'b0);
        gie_pulse(1'b0, 1'b0, 1'b1);
        check("R9 accept clears", {7'b0, gie_o}, 8'h00);
        gie_pulse(1'b1, 1'b0, 1'b1);
        check("R9 accept wins", {7'b0, gie_o}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule